// File: doc/BRIEF.md
# Configurable SPI Master with Transmit and Receive Queues

This block is a serial port controller that runs only as an SPI master. Software programs it through a small word-addressed register interface: words written to the data register are queued, shifted out on MOSI one frame at a time, and the bits captured from MISO during each frame are queued for software to read back. Frame length, bit order, clock idle level, clock phase and the SCK rate are all programmable.

The block reports the fill state of both queues, two programmable fill-level flags and a busy flag. It latches four interrupt causes and drives a single interrupt line. The causes are receive overflow, receive idle timeout and the two fill-level crossings. Each cause has its own enable and is cleared by writing one. An internal loopback path feeds the transmitted bits back into the receiver. Chip select is a plain register-controlled output, and software frames each transaction itself by waiting for busy to drop.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the status register (address 3) reads 0x65, SCK is low, MOSI is low, the chip-select output is high and the interrupt line is low.
- R2: The frame length is DL+1 bits, where DL is control register 0 (address 0) bits [11:8]. DL values 0 and 1 act as 2, giving a 3-bit frame. Words written to the data register (address 7) are right-aligned, and a received word reads back right-aligned with all bits at and above the frame length returning zero.
- R3: SCK rests at the level of control register 1 (address 1) bit 1 whenever no frame is shifting, and it returns to that level at the end of every frame.
- R4: Control register 1 bit 2 selects the clock phase. With 0, MISO is sampled on the leading SCK edge and MOSI changes on the trailing edge. With 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: Control register 1 bit 0 selects the bit order: 0 sends and receives the most significant bit first, 1 sends the least significant bit first.
- R6: The divider register (address 2, bits [7:0]) holds D, and the SCK period is 2*(D+1) system clocks.
- R7: With control register 0 bit 1 set, the receiver takes its bits from MOSI instead of the MISO pin, so each received word equals the word sent.
- R8: Each queue holds 8 words. The status register bits are: transmit empty (bit 0), transmit full (1), receive empty (2), receive full (3), busy (4), transmit level (5) and receive level (6). Transmit level is set while the transmit count is at or below control register 0 bits [14:12]. Receive level is set while the receive count is at or above bits [17:15].
- R9: Busy is set while a frame is shifting or the transmit queue holds a word, and it clears only after the last bit of the last frame.
- R10: A word completed while the receive queue is full is discarded and sets raw cause bit 0 (address 5).
- R11: When the receive queue is not empty and the data register has not been read for 64*(D+1) system clocks (32 SCK periods), raw cause bit 1 is set.
- R12: A rise of the receive level flag sets raw cause bit 2, and a rise of the transmit level flag sets raw cause bit 3. Writing one to a bit of the clear register (address 6) clears that raw cause. The interrupt line is the OR of the raw causes ANDed with the enable register (address 4, same bit order).
- R13: Writing 3 to control register 0 bits [7:6] stops any frame in progress and empties both queues. Those bits always read as zero.
- R14: Frames start only while control register 0 bit 0 is set, and queued words wait while it is clear. The chip-select output follows bit 0 of the select register (address 8), which resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data register pops the receive queue |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Software-controlled chip select |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every combination of idle level, phase and bit order across the shortest, a middle and the longest frame. A bench-side slave captures MOSI on its own sampling edge and returns a known pattern on MISO. A phase or order mistake shows up as a rotated, mirrored or one-bit-shifted word on one side or the other. The sub-minimum length code is checked by counting the edges the slave sees. The SCK period is measured at a divider of 2, which exposes an off-by-one in the half-period count.

The queue boundaries are checked by overrunning the receive queue with nine frames, where a design that overwrites instead of discarding returns a wrong ninth-to-first word. The fill-level flags are checked just below and at their thresholds, where a strict comparison would miss by one. The idle timeout is probed both before and after 64 clocks. The reset command is issued with words still held in a disabled port, and a design that fails to flush leaves busy set.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam logic [3:0] ADR_CTRL0 = 4'd0;
  localparam logic [3:0] ADR_CTRL1 = 4'd1;
  localparam logic [3:0] ADR_DIV   = 4'd2;
  localparam logic [3:0] ADR_STAT  = 4'd3;
  localparam logic [3:0] ADR_IE    = 4'd4;
  localparam logic [3:0] ADR_RIS   = 4'd5;
  localparam logic [3:0] ADR_ICLR  = 4'd6;
  localparam logic [3:0] ADR_DATA  = 4'd7;
  localparam logic [3:0] ADR_CSEL  = 4'd8;

  // Frame length in bits from the length code; codes below 2 act as 2.
  function automatic logic [4:0] frame_bits(input logic [3:0] dl);
    return (dl < 4'd2) ? 5'd3 : ({1'b0, dl} + 5'd1);
  endfunction

  // Mask covering the low n bits of a 16-bit word.
  function automatic logic [15:0] word_mask(input logic [4:0] n);
    logic [16:0] full;
    full = (17'd1 << n) - 17'd1;
    return full[15:0];
  endfunction

  // Word bit position of the idx-th bit on the wire.
  function automatic logic [3:0] bit_pos(input logic [3:0] idx, input logic [4:0] n,
                                         input logic lsb_first);
    logic [4:0] msb_pos;
    msb_pos = n - 5'd1 - {1'b0, idx};
    return lsb_first ? idx : msb_pos[3:0];
  endfunction

  // System clocks of receive inactivity before the timeout cause.
  function automatic int unsigned idle_limit(input logic [7:0] div, input int unsigned periods);
    return periods * 2 * (int'(div) + 1);
  endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        enable,
  input  logic        cpol,
  input  logic        cpha,
  input  logic        lsb_first,
  input  logic [4:0]  n_bits,
  input  logic [7:0]  div,
  input  logic        tx_avail,
  input  logic [15:0] tx_word,
  input  logic        miso_in,
  output logic        tx_pop,
  output logic        rx_valid,
  output logic [15:0] rx_word,
  output logic        sck,
  output logic        mosi,
  output logic        running
);
  logic [7:0]  hc;
  logic [5:0]  e;
  logic [3:0]  bi;
  logic [15:0] txw, rxw;
  logic        lvl;
  logic        edge_now, last, leading, sample, advance;
  logic [3:0]  pos;

  assign pos      = bit_pos(bi, n_bits, lsb_first);
  assign edge_now = running && (hc == div);
  assign last     = (e == ({n_bits, 1'b0} - 6'd1));
  assign leading  = !e[0];
  assign sample   = leading ^ cpha;
  assign advance  = cpha ? (leading && e != 6'd0) : (!leading && !last);
  assign tx_pop   = !running && enable && tx_avail && !flush;
  assign sck      = cpol ^ lvl;
  assign mosi     = txw[pos];
  assign rx_word  = rxw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0; hc <= '0; e <= '0; bi <= '0;
      txw <= '0; rxw <= '0; lvl <= 1'b0; rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (flush) begin
        running <= 1'b0;
        lvl     <= 1'b0;
      end else if (tx_pop) begin
        running <= 1'b1;
        txw <= tx_word; rxw <= '0;
        hc <= '0; e <= '0; bi <= '0; lvl <= 1'b0;
      end else if (edge_now) begin
        hc  <= '0;
        lvl <= ~lvl;
        e   <= e + 6'd1;
        if (sample)  rxw[pos] <= miso_in;
        if (advance) bi <= bi + 4'd1;
        if (last) begin
          running  <= 1'b0;
          rx_valid <= 1'b1;
        end
      end else if (running) begin
        hc <= hc + 8'd1;
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TO_PERIODS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n,
  output logic        irq
);
  localparam int CW  = $clog2(FIFO_DEPTH) + 1;
  localparam int TOW = $clog2(TO_PERIODS * 512 + 1);

  // configuration
  logic       en_q, loop_q, lsb_q, cpol_q, cpha_q, cs_q;
  logic [3:0] dl_q;
  logic [2:0] txth_q, rxth_q;
  logic [7:0] div_q;
  logic [3:0] ie_q, ris_q;

  logic [4:0]  n_bits;
  logic        flush, wr_data, rd_data;
  logic        tx_pop, tx_full, tx_empty, rx_full, rx_empty, rx_valid, running;
  logic [15:0] tx_head, rx_head, rx_word;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic        miso_in, busy, tx_lvl, rx_lvl, tx_lvl_q, rx_lvl_q;
  logic        ovf_evt, to_evt;
  logic [TOW-1:0] to_cnt, to_lim;
  logic [3:0]  ris_set, ris_clr;

  assign n_bits  = frame_bits(dl_q);
  assign flush   = reg_wr && reg_addr == ADR_CTRL0 && reg_wdata[7:6] == 2'b11;
  assign wr_data = reg_wr && reg_addr == ADR_DATA;
  assign rd_data = reg_rd && reg_addr == ADR_DATA;
  assign miso_in = loop_q ? mosi : miso;

  spim_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .flush, .push(wr_data), .din(reg_wdata[15:0]), .pop(tx_pop),
    .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(16), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .flush, .push(rx_valid), .din(rx_word), .pop(rd_data),
    .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spim_shift u_shift (
    .clk, .rst_n, .flush, .enable(en_q), .cpol(cpol_q), .cpha(cpha_q),
    .lsb_first(lsb_q), .n_bits, .div(div_q), .tx_avail(!tx_empty), .tx_word(tx_head),
    .miso_in, .tx_pop, .rx_valid, .rx_word, .sck, .mosi, .running);

  // status and event logic
  assign busy    = running || !tx_empty;
  assign tx_lvl  = (tx_cnt <= CW'(txth_q));
  assign rx_lvl  = (rx_cnt >= CW'(rxth_q));
  assign ovf_evt = rx_valid && rx_full;
  assign to_lim  = TOW'(idle_limit(div_q, TO_PERIODS));
  assign to_evt  = !rx_empty && !rd_data && !flush && (to_cnt == to_lim - TOW'(1));
  assign ris_set = {tx_lvl && !tx_lvl_q, rx_lvl && !rx_lvl_q, to_evt, ovf_evt};
  assign ris_clr = (reg_wr && reg_addr == ADR_ICLR) ? reg_wdata[3:0] : 4'd0;
  assign irq     = |(ris_q & ie_q);
  assign cs_n    = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_cnt <= '0;
    end else if (rx_empty || rd_data || flush) begin
      to_cnt <= '0;
    end else if (to_cnt != to_lim) begin
      to_cnt <= to_cnt + TOW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; loop_q <= 1'b0; dl_q <= 4'd7; txth_q <= '0; rxth_q <= '0;
      lsb_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; div_q <= '0;
      ie_q <= '0; ris_q <= '0; cs_q <= 1'b1;
      tx_lvl_q <= 1'b1; rx_lvl_q <= 1'b1;
    end else begin
      tx_lvl_q <= tx_lvl;
      rx_lvl_q <= rx_lvl;
      ris_q    <= (ris_q & ~ris_clr) | ris_set;
      if (reg_wr) begin
        case (reg_addr)
          ADR_CTRL0: begin
            en_q <= reg_wdata[0]; loop_q <= reg_wdata[1]; dl_q <= reg_wdata[11:8];
            txth_q <= reg_wdata[14:12]; rxth_q <= reg_wdata[17:15];
          end
          ADR_CTRL1: {cpha_q, cpol_q, lsb_q} <= reg_wdata[2:0];
          ADR_DIV:   div_q <= reg_wdata[7:0];
          ADR_IE:    ie_q  <= reg_wdata[3:0];
          ADR_CSEL:  cs_q  <= reg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL0: reg_rdata = {14'd0, rxth_q, txth_q, dl_q, 6'd0, loop_q, en_q};
      ADR_CTRL1: reg_rdata = {29'd0, cpha_q, cpol_q, lsb_q};
      ADR_DIV:   reg_rdata = {24'd0, div_q};
      ADR_STAT:  reg_rdata = {25'd0, rx_lvl, tx_lvl, busy, rx_full, rx_empty, tx_full, tx_empty};
      ADR_IE:    reg_rdata = {28'd0, ie_q};
      ADR_RIS:   reg_rdata = {28'd0, ris_q};
      ADR_DATA:  reg_rdata = {16'd0, rx_head & word_mask(n_bits)};
      ADR_CSEL:  reg_rdata = {31'd0, cs_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int FIFO_DEPTH = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          sck,
  input logic                          cpol,
  input logic                          running,
  input logic                          busy,
  input logic                          tx_empty,
  input logic                          ovf_evt,
  input logic [3:0]                    ris,
  input logic [$clog2(FIFO_DEPTH):0]   tx_cnt,
  input logic                          reg_wr,
  input logic [3:0]                    reg_addr,
  input logic                          cs_n
);
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> sck == cpol);

  p_sck_frame_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> sck == cpol);

  p_busy_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_empty |-> busy);

  p_ovf_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ris[0]);

  p_tx_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= ($clog2(FIFO_DEPTH) + 1)'(FIFO_DEPTH));

  p_cs_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 4'd8) |=> $stable(cs_n));
endmodule

bind spim_ctrl spim_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_spim_checker (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cpol(cpol_q), .running(running),
  .busy(busy), .tx_empty(tx_empty), .ovf_evt(ovf_evt), .ris(ris_q),
  .tx_cnt(tx_cnt), .reg_wr(reg_wr), .reg_addr(reg_addr), .cs_n(cs_n));

// File: tb/test_spim_ctrl.sv
`timescale 1ns/1ps
module test_spim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sck, mosi, miso, cs_n, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spim_ctrl i_spim_ctrl (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
                         .reg_rdata, .sck, .mosi, .miso, .cs_n, .irq);

  // bench-side slave
  int          bk = 0, b_nb = 8;
  logic        b_cpol = 0, b_cpha = 0, b_lsb = 0;
  logic [15:0] b_spat = '0, b_cap = '0;
  time         t_last = 0, t_prev = 0;

  function automatic int bpos(int k);
    return b_lsb ? k : (b_nb - 1 - k);
  endfunction

  assign miso = (bk < b_nb) ? b_spat[bpos(bk)] : 1'b0;

  always @(sck) begin
    if (!cs_n && ((sck != b_cpol) ^ b_cpha) && bk < 16) begin
      b_cap[bpos(bk)] = mosi;
      bk = bk + 1;
    end
  end

  always @(posedge sck) if (!cs_n) begin t_prev = t_last; t_last = $time; end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(4'd3, s);
      if (!s[4]) return;
    end
  endtask

  function automatic logic [31:0] c0(bit en, bit lp, int dl, int txth, int rxth);
    return 32'(en) | (32'(lp) << 1) | (32'(dl) << 8) | (32'(txth) << 12) | (32'(rxth) << 15);
  endfunction

  function automatic logic [15:0] mask(int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic frame(logic [15:0] tx, logic [15:0] pat, int nb);
    b_nb = nb; b_spat = pat; b_cap = '0; bk = 0;
    wr(4'd8, 0);
    wr(4'd7, {16'd0, tx});
    wait_idle();
    wr(4'd8, 1);
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    rd(4'd3, r); chk("R1 status", r, 32'h65);
    chk("R1 sck", {31'd0, sck}, 0);
    chk("R1 mosi", {31'd0, mosi}, 0);
    chk("R1 cs_n", {31'd0, cs_n}, 1);
    chk("R1 irq", {31'd0, irq}, 0);

    // R14: chip select follows the select register
    wr(4'd8, 0); chk("R14 cs low", {31'd0, cs_n}, 0);
    wr(4'd8, 1); chk("R14 cs high", {31'd0, cs_n}, 1);

    // R2 R3 R4 R5: sweep phase, idle level, order and length
    wr(4'd2, 0);
    for (int m = 0; m < 8; m++) begin
      for (int di = 0; di < 3; di++) begin
        int dl;
        logic [15:0] tx, pat;
        dl = (di == 0) ? 2 : (di == 1) ? 7 : 15;
        b_lsb = m[0]; b_cpol = m[1]; b_cpha = m[2];
        wr(4'd1, 32'(m));
        wr(4'd0, c0(1, 0, dl, 0, 0));
        tx  = 16'hA5C3 ^ 16'(m * 16'h1357 + di * 16'h0B1D);
        pat = 16'h3C96 + 16'(m * 77 + di * 301);
        frame(tx, pat, dl + 1);
        chk("R4 R5 mosi word", {16'd0, b_cap}, {16'd0, tx & mask(dl + 1)});
        rd(4'd7, r);
        chk("R2 R4 R5 miso word", r, {16'd0, pat & mask(dl + 1)});
        chk("R3 idle level", {31'd0, sck}, {31'd0, b_cpol});
      end
    end

    // R2: short length code acts as a 3-bit frame
    b_lsb = 0; b_cpol = 0; b_cpha = 0;
    wr(4'd1, 0); wr(4'd0, c0(1, 0, 0, 0, 0));
    frame(16'hFFFF, 16'h0005, 3);
    chk("R2 edge count", 32'(bk), 3);
    rd(4'd7, r); chk("R2 short word", r, 32'h5);

    // R6: SCK period with divider 2
    wr(4'd2, 2); wr(4'd0, c0(1, 0, 7, 0, 0));
    frame(16'h00C3, 16'h0042, 8);
    chk("R6 period", 32'(t_last - t_prev), 48);
    rd(4'd7, r);
    wr(4'd2, 0);

    // R7: loopback
    wr(4'd0, c0(1, 1, 11, 0, 0));
    frame(16'h0ABC, 16'h0000, 12);
    rd(4'd7, r); chk("R7 loopback", r, 32'h0ABC);

    // R10: receive overflow
    wr(4'd6, 15); wr(4'd4, 1);
    wr(4'd0, c0(1, 1, 7, 0, 0));
    for (int i = 0; i < 9; i++) wr(4'd7, 32'(8'h10 + i));
    wait_idle();
    rd(4'd3, r); chk("R8 rx full flag", {31'd0, r[3]}, 1);
    rd(4'd5, r); chk("R10 overflow cause", {31'd0, r[0]}, 1);
    chk("R12 irq enabled cause", {31'd0, irq}, 1);
    for (int i = 0; i < 8; i++) begin
      rd(4'd7, r); chk("R10 kept word", r, 32'(8'h10 + i));
    end
    rd(4'd3, r); chk("R8 rx empty after drain", {31'd0, r[2]}, 1);
    wr(4'd6, 1);
    rd(4'd5, r); chk("R12 write-one clear", {31'd0, r[0]}, 0);
    chk("R12 irq cleared", {31'd0, irq}, 0);

    // R11: receive idle timeout at divider 0 (64 clocks)
    wr(4'd6, 15);
    frame(16'h0033, 16'h0000, 8);
    rd(4'd5, r); chk("R11 no early timeout", {31'd0, r[1]}, 0);
    repeat (70) @(negedge clk);
    rd(4'd5, r); chk("R11 timeout cause", {31'd0, r[1]}, 1);
    rd(4'd7, r); chk("R11 word held", r, 32'h33);

    // R14 R9 R8: disabled port keeps words queued, level flags
    wr(4'd0, c0(0, 1, 7, 2, 3));
    wr(4'd6, 15); wr(4'd4, 0);
    for (int i = 0; i < 3; i++) wr(4'd7, 32'(i + 1));
    rd(4'd3, r); chk("R9 R8 busy while queued", r, 32'h14);
    repeat (20) @(negedge clk);
    rd(4'd3, r); chk("R14 no frame while disabled", r, 32'h14);
    // R13: reset command empties queues
    wr(4'd0, c0(0, 1, 7, 2, 3) | 32'hC0);
    rd(4'd3, r); chk("R13 queues emptied", r, 32'h25);
    rd(4'd0, r); chk("R13 reset bits read zero", {30'd0, r[7:6]}, 0);
    rd(4'd5, r); chk("R12 tx level rise cause", {31'd0, r[3]}, 1);

    // R8 R12: receive level at threshold 3
    wr(4'd0, c0(1, 1, 7, 2, 3));
    wr(4'd6, 15); wr(4'd4, 4);
    wr(4'd7, 32'h21); wr(4'd7, 32'h22);
    wait_idle();
    rd(4'd3, r); chk("R8 rx level below", {31'd0, r[6]}, 0);
    chk("R12 no irq below", {31'd0, irq}, 0);
    wr(4'd7, 32'h23);
    wait_idle();
    rd(4'd3, r); chk("R8 rx level reached", {31'd0, r[6]}, 1);
    rd(4'd5, r); chk("R12 rx level cause", {31'd0, r[2]}, 1);
    chk("R12 irq rx level", {31'd0, irq}, 1);
    for (int i = 0; i < 3; i++) begin
      rd(4'd7, r); chk("R12 queued word", r, 32'(8'h21 + i));
    end
    wr(4'd6, 4);
    chk("R12 irq after clear", {31'd0, irq}, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule